// File: doc/BRIEF.md
# Flash ECC encode, check and correct

This block sits between a processor-side bus and a flash array whose 32-bit data words are each protected by 8 check bits kept in a separate check-bit device. Each bus write is turned into a one-cycle flash write strobe carrying the data word, its address and a freshly computed check byte. Each bus read is turned into a one-cycle flash read strobe. When the flash returns the data word and its stored check byte, the block recomputes the check bits, compares them and classifies the word as clean, single-error or multi-error.

A clean word goes to the bus unchanged. A single-bit error is corrected before the word goes to the bus. A multi-bit error returns the raw word with no correction. Two separate sticky flags, which drive two interrupt lines, tell software which kind of error occurred. The address of the last erroneous read is kept so that software can scrub the word by writing it back. Reads may return a byte, a halfword or the whole word. The check always covers the full 32-bit word.

A small software port drives the flash write-protect pin, clears the error flags and exposes the flash ready/busy pin as a status bit. When a bus write and a bus read arrive in the same cycle, the write is issued and the read is dropped. Only one read may be outstanding at the flash at a time.

Top module: `flash_ecc_guard`

## Requirements
- R1: One cycle after `wr_req`, `fl_we` is high for one cycle and carries `wr_addr`, `wr_data` and a check byte. Check bits 6:0 follow a code in which data bit i has a column equal to the i-th (counting from 0) 7-bit value of exactly three set bits, in ascending numeric order. Check bit j is the XOR of the data bits whose column has bit j set. Check bit 7 makes the XOR of all 40 stored bits equal to 0.
- R2: One cycle after `rd_req`, `fl_re` is high for one cycle with `fl_addr` equal to `rd_addr`. If `wr_req` is high in the same cycle, only the write is issued and `fl_re` stays low.
- R3: One cycle after `fl_rvalid`, `rsp_valid` is high for one cycle. For a word whose check byte matches, `rsp_kind` is 0 (clean) and the data is the stored word, unchanged.
- R4: When exactly one data bit is flipped, `rsp_data` is the corrected word and `rsp_kind` is 1 (single).
- R5: When exactly one check bit (any of bits 7:0) is flipped, `rsp_kind` is 1 and the data is returned unchanged.
- R6: When two bits are flipped, `rsp_kind` is 2 (multi), the raw word is returned uncorrected, and the multi flag (`sw_status[2]`, `irq_multi`) is set.
- R7: `rd_size` selects the width: 0 is a byte, 1 is a halfword, 2 or 3 is a word. A byte uses lane `rd_lane`. A halfword uses half `rd_lane[1]`. The selected lane is zero-extended into the low bits. Correction and classification are always made on the full word.
- R8: A single-error result sets the single flag (`sw_status[1]`, `irq_single`). Both flags stay set until software writes 1 to bit 1 (single) or bit 2 (multi) of `sw_wdata`. A new error that arrives in the same cycle as a clear takes priority, so the flag stays set.
- R9: `err_addr` takes the read address of every single-error or multi-error read. A clean read leaves it unchanged.
- R10: Bit 0 of `sw_wdata`, written with `sw_we`, is a write-enable. `fl_wp_n` and `sw_status[0]` follow it. After reset it is 0, so the flash is protected.
- R11: `sw_status[3]` shows `fl_ready` two clock edges after the pin changes.
- R12: In reset, all strobes, flags, status bits, `fl_wp_n` and `err_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Bus write request (full word) |
| wr_addr | input | ADDR_W | Bus write word address |
| wr_data | input | 32 | Bus write data |
| rd_req | input | 1 | Bus read request |
| rd_addr | input | ADDR_W | Bus read word address |
| rd_size | input | 2 | Read width: 0 byte, 1 half, 2/3 word |
| rd_lane | input | 2 | Byte lane of a narrow read |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read response data |
| rsp_kind | output | 2 | 0 clean, 1 single, 2 multi |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_wcheck | output | 8 | Flash write check byte |
| fl_rvalid | input | 1 | Flash read data valid |
| fl_rdata | input | 32 | Flash read data |
| fl_rcheck | input | 8 | Flash read check byte |
| fl_wp_n | output | 1 | Write-protect pin, low protects |
| fl_ready | input | 1 | Flash ready/busy pin, high ready |
| sw_we | input | 1 | Software control write strobe |
| sw_wdata | input | 3 | Bit 0 write-enable, bits 1/2 clear single/multi flag |
| sw_status | output | 4 | Write-enable, single flag, multi flag, ready |
| err_addr | output | ADDR_W | Address of last erroneous read |
| irq_single | output | 1 | Single-error interrupt |
| irq_multi | output | 1 | Multi-error interrupt |

## Verification
A wrong column table or parity term appears on `fl_wcheck` in the cycle after the write. It also appears one cycle after the flash answers: clean words come back reported as errors, or injected flips are not undone. A wrong syndrome decode shows at that same response as the wrong `rsp_kind` or as data differing from the stored word. A broken flag or address register shows only at the next software-visible sample, through `sw_status`, the interrupt lines or `err_addr`. The bench therefore checks those right after each read.

// File: rtl/flash_ecc_pkg.sv
package flash_ecc_pkg;

  localparam int DATA_W = 32;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;

  typedef enum logic [1:0] {
    RES_CLEAN  = 2'd0,
    RES_SINGLE = 2'd1,
    RES_MULTI  = 2'd2
  } ecc_res_e;

  // Column of data bit idx: the idx-th value of HAM_W bits with three ones
  function automatic logic [HAM_W-1:0] column_code(input int idx);
    int found;
    logic [HAM_W-1:0] res;
    logic [HAM_W-1:0] cand;
    found = 0;
    res   = '0;
    for (int v = 0; v < (1 << HAM_W); v++) begin
      cand = v[HAM_W-1:0];
      if ($countones(cand) == 3) begin
        if (found == idx) res = cand;
        found++;
      end
    end
    return res;
  endfunction

  // Data bits covered by check bit j
  function automatic logic [DATA_W-1:0] cover_mask(input int j);
    logic [DATA_W-1:0] m;
    logic [HAM_W-1:0]  col;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      col  = column_code(i);
      m[i] = col[j];
    end
    return m;
  endfunction

endpackage

// File: rtl/fecc_encode.sv
module fecc_encode
  import flash_ecc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HAM_W,
  localparam int CW = HW + 1
) (
  input  logic [DW-1:0] data,
  output logic [HW-1:0] ham,
  output logic [CW-1:0] chk
);

  for (genvar j = 0; j < HW; j++) begin : g_ham
    localparam logic [DW-1:0] MASK = cover_mask(j);
    assign ham[j] = ^(data & MASK);
  end

  assign chk = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/fecc_check.sv
module fecc_check
  import flash_ecc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HAM_W,
  localparam int CW = HW + 1
) (
  input  logic [DW-1:0] raw_data,
  input  logic [CW-1:0] raw_chk,
  output logic [DW-1:0] fixed_data,
  output ecc_res_e      result
);

  logic [HW-1:0] re_ham;
  logic [CW-1:0] re_chk;
  logic [HW-1:0] syndrome;
  logic          parity_err;
  logic [DW-1:0] hit;
  logic          data_hit;

  fecc_encode #(.DW(DW), .HW(HW)) u_reenc (
    .data (raw_data),
    .ham  (re_ham),
    .chk  (re_chk)
  );

  assign syndrome   = re_ham ^ raw_chk[HW-1:0];
  assign parity_err = ^{raw_data, raw_chk};

  for (genvar i = 0; i < DW; i++) begin : g_hit
    localparam logic [HW-1:0] COL = column_code(i);
    assign hit[i] = (syndrome == COL);
  end

  assign data_hit = |hit;

  always_comb begin
    result     = RES_MULTI;
    fixed_data = raw_data;
    if (!parity_err && syndrome == '0) begin
      result = RES_CLEAN;
    end else if (parity_err && syndrome == '0) begin
      result = RES_SINGLE;
    end else if (parity_err && data_hit) begin
      result     = RES_SINGLE;
      fixed_data = raw_data ^ hit;
    end else if (parity_err && $onehot(syndrome)) begin
      result = RES_SINGLE;
    end
  end

  logic unused_top;
  assign unused_top = re_chk[CW-1];

endmodule

// File: rtl/fecc_swregs.sv
module fecc_swregs #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [2:0]    sw_wdata,
  input  logic          set_single,
  input  logic          set_multi,
  input  logic [AW-1:0] err_addr_in,
  input  logic          ready_pin,
  output logic          wr_en,
  output logic          flag_single,
  output logic          flag_multi,
  output logic          ready_q,
  output logic [AW-1:0] err_addr
);

  logic          wr_en_d, single_d, multi_d;
  logic [AW-1:0] err_addr_d;
  logic          rdy_meta;
  logic          err_event;

  assign err_event = set_single || set_multi;

  always_comb begin
    wr_en_d    = wr_en;
    single_d   = flag_single;
    multi_d    = flag_multi;
    err_addr_d = err_addr;
    if (sw_we) begin
      wr_en_d = sw_wdata[0];
      if (sw_wdata[1]) single_d = 1'b0;
      if (sw_wdata[2]) multi_d  = 1'b0;
    end
    if (set_single) single_d = 1'b1;
    if (set_multi)  multi_d  = 1'b1;
    if (err_event)  err_addr_d = err_addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en       <= 1'b0;
      flag_single <= 1'b0;
      flag_multi  <= 1'b0;
      err_addr    <= '0;
      rdy_meta    <= 1'b0;
      ready_q     <= 1'b0;
    end else begin
      wr_en       <= wr_en_d;
      flag_single <= single_d;
      flag_multi  <= multi_d;
      err_addr    <= err_addr_d;
      rdy_meta    <= ready_pin;
      ready_q     <= rdy_meta;
    end
  end

  // R8
  single_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_single) |-> $past(sw_we && sw_wdata[1]));

  // R8
  multi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_multi |=> flag_multi);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_event |=> $stable(err_addr));

endmodule

// File: rtl/flash_ecc_guard.sv
module flash_ecc_guard
  import flash_ecc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DW     = DATA_W,
  parameter int HW     = HAM_W,
  localparam int CW    = HW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  input  logic [1:0]        rd_lane,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic [1:0]        rsp_kind,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DW-1:0]     fl_wdata,
  output logic [CW-1:0]     fl_wcheck,
  input  logic              fl_rvalid,
  input  logic [DW-1:0]     fl_rdata,
  input  logic [CW-1:0]     fl_rcheck,
  output logic              fl_wp_n,
  input  logic              fl_ready,
  input  logic              sw_we,
  input  logic [2:0]        sw_wdata,
  output logic [3:0]        sw_status,
  output logic [ADDR_W-1:0] err_addr,
  output logic              irq_single,
  output logic              irq_multi
);

  logic [HW-1:0]     enc_ham;
  logic [CW-1:0]     enc_chk;
  logic [DW-1:0]     fixed_data;
  ecc_res_e          chk_res;

  logic              we_d, re_d;
  logic [ADDR_W-1:0] addr_d, pend_addr_q, pend_addr_d;
  logic [DW-1:0]     wdata_d;
  logic [CW-1:0]     wchk_d;
  logic [1:0]        pend_size_q, pend_size_d, pend_lane_q, pend_lane_d;
  logic              rsp_valid_d;
  logic [DW-1:0]     rsp_data_d;
  ecc_res_e          rsp_kind_q, rsp_kind_d;

  logic              set_single, set_multi;
  logic              wr_en, flag_single, flag_multi, ready_q;

  fecc_encode #(.DW(DW), .HW(HW)) u_enc (
    .data (wr_data),
    .ham  (enc_ham),
    .chk  (enc_chk)
  );

  fecc_check #(.DW(DW), .HW(HW)) u_chk (
    .raw_data   (fl_rdata),
    .raw_chk    (fl_rcheck),
    .fixed_data (fixed_data),
    .result     (chk_res)
  );

  function automatic logic [DW-1:0] pick_lane(input logic [DW-1:0] w,
                                              input logic [1:0] sz,
                                              input logic [1:0] ln);
    logic [DW-1:0] sh_b, sh_h;
    sh_b = w >> {ln, 3'b000};
    sh_h = w >> {ln[1], 4'b0000};
    case (sz)
      2'd0:    return {{(DW-8){1'b0}}, sh_b[7:0]};
      2'd1:    return {{(DW-16){1'b0}}, sh_h[15:0]};
      default: return w;
    endcase
  endfunction

  always_comb begin
    we_d        = 1'b0;
    re_d        = 1'b0;
    addr_d      = fl_addr;
    wdata_d     = fl_wdata;
    wchk_d      = fl_wcheck;
    pend_addr_d = pend_addr_q;
    pend_size_d = pend_size_q;
    pend_lane_d = pend_lane_q;
    if (wr_req) begin
      we_d    = 1'b1;
      addr_d  = wr_addr;
      wdata_d = wr_data;
      wchk_d  = enc_chk;
    end else if (rd_req) begin
      re_d        = 1'b1;
      addr_d      = rd_addr;
      pend_addr_d = rd_addr;
      pend_size_d = rd_size;
      pend_lane_d = rd_lane;
    end
    rsp_valid_d = fl_rvalid;
    rsp_data_d  = rsp_data;
    rsp_kind_d  = rsp_kind_q;
    if (fl_rvalid) begin
      rsp_data_d = pick_lane(fixed_data, pend_size_q, pend_lane_q);
      rsp_kind_d = chk_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_we       <= 1'b0;
      fl_re       <= 1'b0;
      fl_addr     <= '0;
      fl_wdata    <= '0;
      fl_wcheck   <= '0;
      pend_addr_q <= '0;
      pend_size_q <= '0;
      pend_lane_q <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_kind_q  <= RES_CLEAN;
    end else begin
      fl_we       <= we_d;
      fl_re       <= re_d;
      fl_addr     <= addr_d;
      fl_wdata    <= wdata_d;
      fl_wcheck   <= wchk_d;
      pend_addr_q <= pend_addr_d;
      pend_size_q <= pend_size_d;
      pend_lane_q <= pend_lane_d;
      rsp_valid   <= rsp_valid_d;
      rsp_data    <= rsp_data_d;
      rsp_kind_q  <= rsp_kind_d;
    end
  end

  assign rsp_kind   = rsp_kind_q;
  assign set_single = fl_rvalid && (chk_res == RES_SINGLE);
  assign set_multi  = fl_rvalid && (chk_res == RES_MULTI);

  fecc_swregs #(.AW(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_we       (sw_we),
    .sw_wdata    (sw_wdata),
    .set_single  (set_single),
    .set_multi   (set_multi),
    .err_addr_in (pend_addr_q),
    .ready_pin   (fl_ready),
    .wr_en       (wr_en),
    .flag_single (flag_single),
    .flag_multi  (flag_multi),
    .ready_q     (ready_q),
    .err_addr    (err_addr)
  );

  assign fl_wp_n    = wr_en;
  assign irq_single = flag_single;
  assign irq_multi  = flag_multi;
  assign sw_status  = {ready_q, flag_multi, flag_single, wr_en};

  logic unused_ham;
  assign unused_ham = ^enc_ham;

  // R1
  wr_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> (fl_we && ((^{fl_wcheck, fl_wdata}) == 1'b0)));

  // R2
  rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_req) |=> (fl_re && !fl_we));

  // R3
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rvalid |=> rsp_valid);

  // R6
  multi_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RES_MULTI) |-> irq_multi);

endmodule

// File: tb/flash_ecc_guard_tb_top.sv
module flash_ecc_guard_tb_top;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_req, rd_req, sw_we, fl_rvalid, fl_ready;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data, fl_rdata;
  logic [1:0]    rd_size, rd_lane;
  logic [7:0]    fl_rcheck;
  logic [2:0]    sw_wdata;
  logic          rsp_valid, fl_we, fl_re, fl_wp_n, irq_single, irq_multi;
  logic [31:0]   rsp_data, fl_wdata;
  logic [1:0]    rsp_kind;
  logic [AW-1:0] fl_addr, err_addr;
  logic [7:0]    fl_wcheck;
  logic [3:0]    sw_status;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [39:0] mem [int];
  logic [39:0] inj;
  logic [33:0] exp_q [$];

  always #4 clk = ~clk;

  flash_ecc_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_lane(rd_lane),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_kind(rsp_kind),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_wcheck(fl_wcheck), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata),
    .fl_rcheck(fl_rcheck), .fl_wp_n(fl_wp_n), .fl_ready(fl_ready),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_status(sw_status),
    .err_addr(err_addr), .irq_single(irq_single), .irq_multi(irq_multi)
  );

  function automatic logic [7:0] ref_check(input logic [31:0] d);
    logic [6:0] cols [32];
    logic [6:0] ham;
    int n;
    n = 0;
    for (int v = 0; v < 128; v++) begin
      if ($countones(v[6:0]) == 3 && n < 32) begin
        cols[n] = v[6:0];
        n++;
      end
    end
    ham = '0;
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 7; j++)
        if (cols[i][j]) ham[j] = ham[j] ^ d[i];
    return {(^d) ^ (^ham), ham};
  endfunction

  task automatic check(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Flash model, acts at the falling edge
  always @(negedge clk) begin
    if (fl_we) mem[int'(fl_addr)] = {fl_wcheck, fl_wdata};
    if (fl_re) begin
      fl_rvalid = 1'b1;
      {fl_rcheck, fl_rdata} = mem[int'(fl_addr)] ^ inj;
    end else begin
      fl_rvalid = 1'b0;
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected response", {6'd0, rsp_kind, rsp_data}, '0);
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        check({rsp_kind, rsp_data} == e, "R3-R7 response",
              {6'd0, rsp_kind, rsp_data}, {6'd0, e});
      end
    end
  end

  task automatic sw_write(input logic [2:0] v);
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = v;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
    check(fl_we && fl_addr == a && fl_wdata == d, "R1 write strobe",
          {fl_we, 7'd0, fl_wdata}, {1'b1, 7'd0, d});
    check(fl_wcheck == ref_check(d), "R1 check byte",
          {32'd0, fl_wcheck}, {32'd0, ref_check(d)});
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] sz,
                         input logic [1:0] ln, input logic [39:0] m,
                         input logic [31:0] exp_d, input logic [1:0] exp_k);
    @(negedge clk);
    inj = m; rd_req = 1'b1; rd_addr = a; rd_size = sz; rd_lane = ln;
    exp_q.push_back({exp_k, exp_d});
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R3 response arrived", {39'd0, 1'b0}, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_req = 0; rd_req = 0; sw_we = 0; sw_wdata = '0;
    wr_addr = '0; rd_addr = '0; wr_data = '0; rd_size = 2'd2; rd_lane = '0;
    fl_ready = 1'b0; fl_rvalid = 1'b0; fl_rdata = '0; fl_rcheck = '0; inj = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!fl_we && !fl_re && !rsp_valid && !fl_wp_n && sw_status == 4'd0 &&
          err_addr == '0 && !irq_single && !irq_multi, "R12 reset state",
          {34'd0, fl_we, fl_re, rsp_valid, fl_wp_n, irq_single, irq_multi}, '0);
    rst_n = 1'b1;

    // R10 enable writes
    sw_write(3'b001);
    check(fl_wp_n && sw_status[0], "R10 write enable on",
          {38'd0, fl_wp_n, sw_status[0]}, 40'd3);

    // R1 writes of several patterns
    do_write(20'd5,  32'h1234_5678);
    do_write(20'd9,  32'hFFFF_FFFF);
    do_write(20'd12, 32'h0000_0000);
    do_write(20'd20, 32'hA5C3_0F96);

    // R3 clean reads
    do_read(20'd5,  2'd2, 2'd0, '0, 32'h1234_5678, 2'd0);
    do_read(20'd9,  2'd2, 2'd0, '0, 32'hFFFF_FFFF, 2'd0);
    do_read(20'd12, 2'd2, 2'd0, '0, 32'h0000_0000, 2'd0);
    do_read(20'd20, 2'd2, 2'd0, '0, 32'hA5C3_0F96, 2'd0);
    check(sw_status[2:1] == 2'b00 && err_addr == '0, "R9 clean reads leave state",
          {18'd0, err_addr, sw_status[2:1]}, '0);

    // R4 single data-bit errors
    do_read(20'd5, 2'd2, 2'd0, 40'h1, 32'h1234_5678, 2'd1);
    check(irq_single && sw_status[1] && err_addr == 20'd5, "R8 R9 single flag and address",
          {19'd0, err_addr, irq_single}, {19'd0, 20'd5, 1'b1});
    do_read(20'd9, 2'd2, 2'd0, 40'h80000000, 32'hFFFF_FFFF, 2'd1);
    check(err_addr == 20'd9, "R9 address update", {20'd0, err_addr}, 40'd9);

    // R9 clean read keeps address, R8 flag sticky
    do_read(20'd12, 2'd2, 2'd0, '0, 32'h0, 2'd0);
    check(err_addr == 20'd9 && irq_single, "R9 R8 hold after clean read",
          {19'd0, err_addr, irq_single}, {19'd0, 20'd9, 1'b1});

    // R8 write-one-to-clear
    sw_write(3'b011);
    check(!irq_single && sw_status[1:0] == 2'b01, "R8 clear single flag",
          {38'd0, sw_status[1:0]}, 40'd1);

    // R5 check-bit errors
    do_read(20'd20, 2'd2, 2'd0, 40'h08_0000_0000, 32'hA5C3_0F96, 2'd1);
    do_read(20'd20, 2'd2, 2'd0, 40'h80_0000_0000, 32'hA5C3_0F96, 2'd1);
    check(irq_single && !irq_multi, "R5 check-bit error flags",
          {38'd0, irq_multi, irq_single}, 40'd1);

    // R6 double errors
    do_read(20'd5, 2'd2, 2'd0, 40'h408, 32'h1234_5678 ^ 32'h408, 2'd2);
    check(irq_multi && sw_status[2] && err_addr == 20'd5, "R6 multi flag",
          {19'd0, err_addr, irq_multi}, {19'd0, 20'd5, 1'b1});
    do_read(20'd9, 2'd2, 2'd0, 40'h02_0000_0080, 32'hFFFF_FF7F, 2'd2);

    // R7 narrow reads
    do_read(20'd20, 2'd0, 2'd2, 40'h2, 32'h0000_00C3, 2'd1);
    do_read(20'd5,  2'd1, 2'd2, '0, 32'h0000_1234, 2'd0);
    do_read(20'd5,  2'd0, 2'd3, 40'h3, 32'h0000_0012, 2'd2);
    do_read(20'd20, 2'd1, 2'd0, 40'h10000, 32'h0000_0F96, 2'd1);

    // R8 clear multi
    sw_write(3'b101);
    check(!irq_multi && sw_status[2:0] == 3'b011, "R8 clear multi flag",
          {37'd0, sw_status[2:0]}, 40'd3);

    // R2 write wins over read
    @(negedge clk);
    wr_req = 1'b1; wr_addr = 20'd30; wr_data = 32'hCAFE_0001;
    rd_req = 1'b1; rd_addr = 20'd5;
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
    check(fl_we && !fl_re && fl_addr == 20'd30, "R2 write priority",
          {18'd0, fl_addr, fl_we, fl_re}, {18'd0, 20'd30, 2'b10});
    repeat (2) @(negedge clk);
    do_read(20'd30, 2'd2, 2'd0, '0, 32'hCAFE_0001, 2'd0);

    // R2 read strobe and address
    @(negedge clk);
    inj = '0; rd_req = 1'b1; rd_addr = 20'd12; rd_size = 2'd2;
    exp_q.push_back({2'd0, 32'h0});
    @(negedge clk);
    rd_req = 1'b0;
    check(fl_re && !fl_we && fl_addr == 20'd12, "R2 read strobe",
          {18'd0, fl_addr, fl_re, fl_we}, {18'd0, 20'd12, 2'b10});
    repeat (3) @(negedge clk);

    // R10 protect again
    sw_write(3'b000);
    check(!fl_wp_n && !sw_status[0], "R10 write enable off",
          {38'd0, fl_wp_n, sw_status[0]}, '0);

    // R11 ready synchroniser latency
    @(negedge clk);
    fl_ready = 1'b1;
    @(negedge clk);
    check(!sw_status[3], "R11 ready not yet", {39'd0, sw_status[3]}, '0);
    @(negedge clk);
    check(sw_status[3], "R11 ready after two edges", {39'd0, sw_status[3]}, 40'd1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule